// File: doc/BRIEF.md
# Bitplane Fetch Window Gate

This block decides, for every horizontal color-clock position of a video line, whether the bitplane slot sequencer may issue memory fetches. It keeps its own horizontal position counter. The counter advances once per clock and returns to zero after an external end-of-line strobe. Software programs three values through a small register-write port: a fetch start position, a fetch stop position and a behaviour mode. An enable latch turns on when the counter matches the start position and turns off when it matches the stop position. The registered window flag is the AND of that latch with a fixed lower position limit, below which no fetch is ever allowed.

The two modes differ only at the end of a line. In hard-stop mode, the end-of-line strobe always clears the latch. A stop value beyond the line length therefore does no harm: each line waits for its start position again. In programmable mode there is no hard stop. If the stop position is never reached, the latch carries into the next line. Fetching then resumes as soon as the counter reaches the lower limit, and the start value has no effect.

Top module: `fetch_window_gate`

## Requirements
- R1: While reset is high and on the first clock after it, `fetch_o` is 0 and `hpos_o` is 0. The latch is clear, start and stop are 0, and the mode is hard-stop.
- R2: `hpos_o` increases by one on each clock. On the clock after a cycle with `line_end` high it is 0.
- R3: `fetch_o` is never 1 on the clock after a position below 0x18, whatever the latch holds.
- R4: When the position equals the start value and differs from the stop value, `fetch_o` is 1 on the next clock. This assumes the position is at least 0x18 and no hard stop applies. The output is registered, so it always reflects the position one clock earlier.
- R5: When the position equals the stop value, `fetch_o` is 0 on the next clock, and it stays 0 until the start position is matched again.
- R6: When start and stop are equal, clearing wins and the window never opens.
- R7: In hard-stop mode (mode bit 0 = 0), a cycle with `line_end` high clears the latch. With a stop value beyond the line, each new line fetches only from its start position onward.
- R8: In programmable mode (mode bit 0 = 1), `line_end` leaves the latch unchanged. With a stop value beyond the line, the next line fetches from position 0x18 onward, ignoring the start value.
- R9: A write with `wr_en` high updates one register. Address 0 holds start, address 1 holds stop, and address 2 holds the mode in bit 0. The written value is used from the next clock onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one color clock per cycle |
| rst | input | 1 | Synchronous active-high reset |
| line_end | input | 1 | High on the last position of a line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start, 1 stop, 2 mode |
| wr_data | input | 8 | Write data |
| hpos_o | output | 8 | Current horizontal position |
| fetch_o | output | 1 | Registered fetch-window-active flag |

## Verification
A corrupted enable latch shows at `fetch_o` on the very next clock, provided the position is at or above 0x18. Below that position it stays hidden until the counter reaches the limit, at most 0x18 clocks later. A counter that misses its wrap shows at `hpos_o` immediately. It also shifts every later start and stop match, so the window edges move within the same line. A mode error shows only on the first line that follows a line where the stop value was never matched. Each configuration therefore runs for three lines so that carry-over between lines is visible.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    // Width of the horizontal position and of the start/stop registers
    parameter int POS_W  = 8;
    // Width of the register address
    parameter int ADDR_W = 2;

    typedef enum logic {
        MODE_HARD_STOP = 1'b0,
        MODE_PROG      = 1'b1
    } mode_t;

    // Register addresses
    localparam logic [ADDR_W-1:0] ADDR_START = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STOP  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE  = 2'd2;

    typedef struct packed {
        logic [POS_W-1:0] start;
        logic [POS_W-1:0] stop;
        mode_t            mode;
    } cfg_t;

    // Next state of the enable latch for one position.
    // Clearing wins over setting; a hard stop wins over both.
    function automatic logic latch_next(
        input logic             cur,
        input logic [POS_W-1:0] pos,
        input cfg_t             cfg,
        input logic             eol
    );
        logic n;
        n = cur;
        if (pos == cfg.start) n = 1'b1;
        if (pos == cfg.stop)  n = 1'b0;
        if (eol && cfg.mode == MODE_HARD_STOP) n = 1'b0;
        return n;
    endfunction

endpackage

// File: rtl/fwg_hcounter.sv
module fwg_hcounter
    import fwg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    output logic [POS_W-1:0] hpos
);

    always_ff @(posedge clk) begin
        if (rst)
            hpos <= '0;
        else if (line_end)
            hpos <= '0;
        else
            hpos <= hpos + 1'b1;
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (hpos == '0));

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (hpos == $past(hpos) + 1'b1));

endmodule

// File: rtl/fwg_cfg_regs.sv
module fwg_cfg_regs
    import fwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [POS_W-1:0]  wr_data,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.start <= '0;
            cfg.stop  <= '0;
            cfg.mode  <= MODE_HARD_STOP;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_START: cfg.start <= wr_data;
                ADDR_STOP:  cfg.stop  <= wr_data;
                ADDR_MODE:  cfg.mode  <= mode_t'(wr_data[0]);
                default:    ;
            endcase
        end
    end

    assert_start_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_START) |=> (cfg.start == $past(wr_data)));

    assert_stop_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == ADDR_STOP) |=> (cfg.stop == $past(wr_data)));

endmodule

// File: rtl/fwg_window.sv
module fwg_window
    import fwg_pkg::*;
#(
    parameter logic [POS_W-1:0] MIN_POS = 8'h18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] hpos,
    input  logic             line_end,
    input  cfg_t             cfg,
    output logic             fetch_o
);

    logic latch_q;
    logic latch_d;
    logic above_min;

    always_comb begin
        latch_d   = latch_next(latch_q, hpos, cfg, line_end);
        above_min = (hpos >= MIN_POS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            fetch_o <= 1'b0;
        end else begin
            latch_q <= latch_d;
            fetch_o <= latch_d && above_min;
        end
    end

    assert_min_limit_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_o |-> ($past(hpos) >= MIN_POS));

    assert_stop_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (hpos == cfg.stop) |=> !fetch_o);

    assert_start_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (hpos == cfg.start && hpos != cfg.stop && hpos >= MIN_POS &&
         !(line_end && cfg.mode == MODE_HARD_STOP)) |=> fetch_o);

    assert_hard_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (line_end && cfg.mode == MODE_HARD_STOP) |=> !fetch_o);

endmodule

// File: rtl/fetch_window_gate.sv
module fetch_window_gate
    import fwg_pkg::*;
#(
    parameter logic [POS_W-1:0] MIN_POS = 8'h18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_end,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [POS_W-1:0]  wr_data,
    output logic [POS_W-1:0]  hpos_o,
    output logic              fetch_o
);

    cfg_t cfg;

    fwg_hcounter u_hcnt (
        .clk      (clk),
        .rst      (rst),
        .line_end (line_end),
        .hpos     (hpos_o)
    );

    fwg_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg)
    );

    fwg_window #(.MIN_POS(MIN_POS)) u_win (
        .clk      (clk),
        .rst      (rst),
        .hpos     (hpos_o),
        .line_end (line_end),
        .cfg      (cfg),
        .fetch_o  (fetch_o)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!fetch_o && hpos_o == '0));

endmodule

// File: tb/test_fetch_window_gate.sv
module test_fetch_window_gate;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 100;
    localparam int MINP       = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       line_end = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] hpos_o;
    logic       fetch_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    int m_h, m_latch, m_fetch, m_start, m_stop, m_mode;
    bit first_after_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_window_gate i_fetch_window_gate (
        .clk(clk), .rst(rst), .line_end(line_end), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .hpos_o(hpos_o), .fetch_o(fetch_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (hpos model %0d)", req, act, exp, m_h);
        end
    endtask

    // One clock: model next state from current inputs, then compare at negedge
    task automatic cycle();
        int nl, nf, nh;
        string tag;
        if (rst) begin
            nl = 0; nf = 0; nh = 0;
        end else begin
            nl = m_latch;
            if (m_h == m_start) nl = 1;
            if (m_h == m_stop)  nl = 0;
            if (line_end && m_mode == 0) nl = 0;
            nf = (nl != 0 && m_h >= MINP) ? 1 : 0;
            nh = line_end ? 0 : (m_h + 1) % 256;
        end
        if (rst)                          tag = "R1";
        else if (first_after_cfg)         tag = "R9";
        else if (m_start == m_stop)       tag = "R6";
        else if (m_stop >= LINE_LEN)      tag = (m_mode != 0) ? "R8" : "R7";
        else if (nl != 0 && m_h < MINP)   tag = "R3";
        else                              tag = (nf != 0) ? "R4" : "R5";
        @(posedge clk);
        if (rst) begin
            m_start = 0; m_stop = 0; m_mode = 0;
        end else if (wr_en) begin
            if (wr_addr == 2'd0) m_start = wr_data;
            if (wr_addr == 2'd1) m_stop  = wr_data;
            if (wr_addr == 2'd2) m_mode  = wr_data[0];
        end
        m_latch = nl; m_fetch = nf; m_h = nh;
        @(negedge clk);
        check(rst ? "R1" : "R2", hpos_o, m_h);
        check(tag, fetch_o, m_fetch);
        if (tag == "R9" && !wr_en) first_after_cfg = 0;
    endtask

    task automatic drive_eol();
        line_end = (m_h == LINE_LEN - 1);
    endtask

    task automatic write_reg(input int a, input int d);
        wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[7:0];
        drive_eol();
        cycle();
        wr_en = 1'b0;
    endtask

    task automatic run_config(input int st, input int sp, input int md);
        rst = 1'b1; line_end = 1'b0;
        cycle();
        cycle();
        rst = 1'b0;
        // R1: state right after reset
        check("R1", fetch_o, 0);
        check("R1", hpos_o, 0);
        write_reg(0, st);
        write_reg(1, sp);
        write_reg(2, md);
        first_after_cfg = 1;
        for (int i = 0; i < 3 * LINE_LEN; i++) begin
            drive_eol();
            cycle();
        end
    endtask

    initial begin
        int starts[4] = '{8'h10, 8'h18, 8'h20, 8'h40};
        int stops[4]  = '{8'h30, 8'h40, 8'h60, 8'hC8};
        m_h = 0; m_latch = 0; m_fetch = 0; m_start = 0; m_stop = 0; m_mode = 0;
        first_after_cfg = 0;
        @(negedge clk);
        for (int md = 0; md < 2; md++) begin
            for (int s = 0; s < 4; s++) begin
                for (int p = 0; p < 4; p++)
                    run_config(starts[s], stops[p], md);
                // equal start and stop
                run_config(starts[s], starts[s], md);
            end
        end
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 190000; c++) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule